// File: doc/BRIEF.md
# USB IN Endpoint Handshake Responder

This block decides the reply to each IN token for one bulk or interrupt IN endpoint of a USB device. When a token addressed to the endpoint arrives, the block looks at the halt flag and at the buffer-ready flag. It answers with a data packet that carries the current toggle PID, with NAK, or with STALL. NAK and STALL carry no data. After a data packet it waits for the host's reply. Only an ACK moves the endpoint forward: the toggle flips and the buffer is released. If the host reports a corrupted packet, it sends no handshake. In that case the turnaround timer expires, and the same payload with the same PID is sent again on the next token.

Packet serialisation and CRC are done outside this block. The block only emits a one-cycle response strobe with a response kind and a data PID, plus a one-cycle buffer-release pulse. The turnaround timeout is set in bit times through parameters.

Top module: `usb_in_ep_responder`

## Requirements
- R1: After reset, and in the cycle after `ep_config` is high, the data toggle is DATA0 (`data_pid` = 0 for the next data response, where 0 means DATA0 and 1 means DATA1). `ep_config` also abandons any pending handshake wait, and a token in the same cycle is not answered.
- R2: An `in_token` sampled while idle, with `halt` low and `buf_ready` high, gives `resp_valid` high for exactly one cycle at the next clock. That cycle carries `resp_kind` = 2'b01 (DATA) and `data_pid` equal to the current toggle. The block then enters the handshake wait (`hs_wait` high).
- R3: An `in_token` sampled while idle, with `halt` low and `buf_ready` low, gives one `resp_valid` cycle with `resp_kind` = 2'b10 (NAK). No handshake wait follows.
- R4: An `in_token` sampled while idle with `halt` high gives `resp_kind` = 2'b11 (STALL), whatever `buf_ready` is. No handshake wait follows.
- R5: If no `hs_ack` arrives within TIMEOUT_BITS*CLKS_PER_BIT clock cycles of entering the wait, the block returns to idle. The toggle is unchanged and no release pulse is given, so the next data response repeats the same PID.
- R6: An `hs_ack` sampled during the wait flips the toggle and gives a one-cycle `buf_release` pulse at the next clock. The block then returns to idle.
- R7: Inputs that arrive outside their phase are ignored. An `hs_ack` outside the wait gives no release and does not change the toggle. An `in_token` during the wait gives no response.
- R8: A falling edge of `halt` resets the toggle to DATA0. This takes priority over an ACK flip in the same cycle.
- R9: `buf_ready` is sampled only at the IN token. Changes between tokens have no effect on the outputs until the next token.
- R10: Outside a response cycle, `resp_valid` is low and `resp_kind` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ep_config | input | 1 | Endpoint (re)configuration strobe; clears the toggle |
| in_token | input | 1 | One-cycle strobe: IN token for this endpoint received |
| buf_ready | input | 1 | Transmit buffer holds a packet to send |
| halt | input | 1 | Endpoint halted |
| hs_ack | input | 1 | One-cycle strobe: host ACK handshake decoded |
| resp_valid | output | 1 | One-cycle strobe: response decided |
| resp_kind | output | 2 | 00 none, 01 DATA, 10 NAK, 11 STALL |
| data_pid | output | 1 | PID of the last data response: 0 DATA0, 1 DATA1 |
| buf_release | output | 1 | One-cycle pulse: buffer acknowledged, may be freed |
| hs_wait | output | 1 | Waiting for the host handshake |

## Verification
A toggle that is wrong inside the block stays hidden until the next data response. There it shows up as the wrong `data_pid`. The bench therefore follows every ACK, timeout, halt clear and reconfiguration with a data token, and compares the PID in the cycle after that token. A stuck or miscounted turnaround timer shows up at `hs_wait`. It is visible in the exact cycle where the wait should have ended, and on every cycle the bench compares against its own model. A wrong release decision shows up on `buf_release` one clock after the handshake input.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;

  typedef enum logic [1:0] {
    RESP_NONE  = 2'b00,
    RESP_DATA  = 2'b01,
    RESP_NAK   = 2'b10,
    RESP_STALL = 2'b11
  } resp_kind_t;

  // Halt wins over a ready buffer; no data means NAK.
  function automatic resp_kind_t pick_resp(input logic halted, input logic ready);
    if (halted)     return RESP_STALL;
    else if (ready) return RESP_DATA;
    else            return RESP_NAK;
  endfunction

  // A clear beats an acknowledged flip.
  function automatic logic next_toggle(input logic cur, input logic clear, input logic acked);
    if (clear)      return 1'b0;
    else if (acked) return ~cur;
    else            return cur;
  endfunction

  function automatic int unsigned timeout_clks(input int unsigned bits, input int unsigned clks_per_bit);
    return bits * clks_per_bit;
  endfunction

endpackage

// File: rtl/ep_turnaround_timer.sv
module ep_turnaround_timer #(
  parameter int unsigned LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  assign expire = run && (cnt == CW'(LIMIT - 1));

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < CW'(LIMIT)));
endmodule

// File: rtl/ep_toggle_reg.sv
module ep_toggle_reg
  import usb_in_ep_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic flip,
  output logic toggle
);
  always_ff @(posedge clk) begin
    if (!rst_n) toggle <= 1'b0;
    else        toggle <= next_toggle(toggle, clear, flip);
  end

  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (toggle == 1'b0));
  assert_flip_changes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flip && !clear) |=> (toggle != $past(toggle)));
  assert_hold_otherwise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flip && !clear) |=> $stable(toggle));
endmodule

// File: rtl/ep_response_sel.sv
module ep_response_sel
  import usb_in_ep_pkg::*;
(
  input  logic       halted,
  input  logic       ready,
  output logic [1:0] kind
);
  always_comb kind = pick_resp(halted, ready);

  always_comb begin
    assert_stall_priority_R4: assert (!halted || kind == RESP_STALL);
  end
endmodule

// File: rtl/usb_in_ep_responder.sv
module usb_in_ep_responder
  import usb_in_ep_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 4,
  parameter int unsigned TIMEOUT_BITS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ep_config,
  input  logic       in_token,
  input  logic       buf_ready,
  input  logic       halt,
  input  logic       hs_ack,
  output logic       resp_valid,
  output logic [1:0] resp_kind,
  output logic       data_pid,
  output logic       buf_release,
  output logic       hs_wait
);
  localparam int unsigned LIMIT = timeout_clks(TIMEOUT_BITS, CLKS_PER_BIT);

  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} state_t;
  state_t state;

  logic       halt_q;
  logic       toggle;
  logic       timer_expire;
  logic       ack_take;
  logic       tog_clear;
  logic       token_take;
  logic [1:0] sel_kind;

  // Named internal events
  assign ack_take   = (state == ST_WAIT) && hs_ack && !ep_config;
  assign tog_clear  = ep_config || (halt_q && !halt);
  assign token_take = (state == ST_IDLE) && in_token && !ep_config;

  ep_response_sel u_sel (
    .halted (halt),
    .ready  (buf_ready),
    .kind   (sel_kind)
  );

  ep_toggle_reg u_tog (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (tog_clear),
    .flip   (ack_take),
    .toggle (toggle)
  );

  ep_turnaround_timer #(.LIMIT(LIMIT)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (state == ST_WAIT),
    .expire (timer_expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      halt_q      <= 1'b0;
      resp_valid  <= 1'b0;
      resp_kind   <= RESP_NONE;
      data_pid    <= 1'b0;
      buf_release <= 1'b0;
    end else begin
      halt_q      <= halt;
      resp_valid  <= 1'b0;
      resp_kind   <= RESP_NONE;
      buf_release <= 1'b0;
      if (ep_config) begin
        state <= ST_IDLE;
      end else if (state == ST_WAIT) begin
        if (ack_take) begin
          buf_release <= 1'b1;
          state       <= ST_IDLE;
        end else if (timer_expire) begin
          state <= ST_IDLE;
        end
      end else if (token_take) begin
        resp_valid <= 1'b1;
        resp_kind  <= sel_kind;
        data_pid   <= toggle;
        if (sel_kind == RESP_DATA) state <= ST_WAIT;
      end
    end
  end

  assign hs_wait = (state == ST_WAIT);

  assert_cfg_toggle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ep_config |=> (toggle == 1'b0) && !hs_wait);
  assert_data_enters_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (token_take && !halt && buf_ready) |=> resp_valid && resp_kind == RESP_DATA && hs_wait);
  assert_nak_no_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (token_take && !halt && !buf_ready) |=> resp_kind == RESP_NAK && !hs_wait);
  assert_stall_on_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (token_take && halt) |=> resp_kind == RESP_STALL && !hs_wait);
  assert_timeout_no_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_expire && !hs_ack && !ep_config) |=> !buf_release && !hs_wait);
  assert_release_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_release |-> $past(hs_ack) && $past(hs_wait));
  assert_no_reply_in_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_wait && in_token) |=> !resp_valid);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> resp_kind == RESP_NONE);
endmodule

// File: tb/usb_in_ep_responder_tb.sv
module usb_in_ep_responder_tb_top;
  localparam int CPB   = 4;
  localparam int TBITS = 16;
  localparam int LIMIT = CPB * TBITS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ep_config = 1'b0, in_token = 1'b0, buf_ready = 1'b0, halt = 1'b0, hs_ack = 1'b0;
  logic resp_valid, data_pid, buf_release, hs_wait;
  logic [1:0] resp_kind;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usb_in_ep_responder #(.CLKS_PER_BIT(CPB), .TIMEOUT_BITS(TBITS)) dut_i (
    .clk(clk), .rst_n(rst_n), .ep_config(ep_config), .in_token(in_token),
    .buf_ready(buf_ready), .halt(halt), .hs_ack(hs_ack),
    .resp_valid(resp_valid), .resp_kind(resp_kind), .data_pid(data_pid),
    .buf_release(buf_release), .hs_wait(hs_wait)
  );

  // Behavioural reference model
  int m_tog = 0, m_wait = 0, m_cnt = 0, m_halt_prev = 0;
  int e_valid = 0, e_kind = 0, e_pid = 0, e_rel = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tog = 0; m_wait = 0; m_cnt = 0; m_halt_prev = 0;
      e_valid = 0; e_kind = 0; e_pid = 0; e_rel = 0;
    end else begin
      int clr;
      clr = (ep_config || (m_halt_prev == 1 && !halt)) ? 1 : 0;
      e_valid = 0; e_kind = 0; e_rel = 0;
      if (ep_config) begin
        m_wait = 0;
      end else if (m_wait == 1) begin
        if (hs_ack) begin
          e_rel = 1; m_wait = 0;
          if (clr == 0) m_tog = 1 - m_tog;
        end else if (m_cnt == LIMIT - 1) m_wait = 0;
        else m_cnt++;
      end else if (in_token) begin
        e_valid = 1;
        e_pid = m_tog;
        if (halt) e_kind = 3;
        else if (buf_ready) begin e_kind = 1; m_wait = 1; m_cnt = 0; end
        else e_kind = 2;
      end
      if (clr == 1) m_tog = 0;
      m_halt_prev = halt ? 1 : 0;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2", "resp_valid", int'(resp_valid), e_valid);
      chk(e_kind == 3 ? "R4" : (e_kind == 2 ? "R3" : "R10"), "resp_kind", int'(resp_kind), e_kind);
      chk("R1", "data_pid", int'(data_pid), e_pid);
      chk("R6", "buf_release", int'(buf_release), e_rel);
      chk("R5", "hs_wait", int'(hs_wait), m_wait);
    end
  end

  task automatic token_and_check(input string req, input int exp_kind, input int exp_pid);
    @(negedge clk) in_token = 1'b1;
    @(negedge clk) in_token = 1'b0;
    chk(req, "directed resp_valid", int'(resp_valid), 1);
    chk(req, "directed resp_kind", int'(resp_kind), exp_kind);
    if (exp_kind == 1) chk(req, "directed data_pid", int'(data_pid), exp_pid);
  endtask

  task automatic send_ack(input int exp_rel);
    @(negedge clk) hs_ack = 1'b1;
    @(negedge clk) hs_ack = 1'b0;
    chk(exp_rel == 1 ? "R6" : "R7", "directed buf_release", int'(buf_release), exp_rel);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R10 reset state
    chk("R10", "reset resp_valid", int'(resp_valid), 0);
    chk("R1", "reset data_pid", int'(data_pid), 0);
    chk("R1", "reset hs_wait", int'(hs_wait), 0);

    token_and_check("R3", 2, 0);                   // no data -> NAK
    buf_ready = 1'b1;
    token_and_check("R2", 1, 0);                   // DATA0
    chk("R2", "wait after data", int'(hs_wait), 1);
    @(negedge clk) in_token = 1'b1;                // R7 token during wait ignored
    @(negedge clk) in_token = 1'b0;
    chk("R7", "no reply in wait", int'(resp_valid), 0);
    send_ack(1);                                    // R6 release, flip
    token_and_check("R6", 1, 1);                   // DATA1 after ACK
    repeat (LIMIT + 2) @(negedge clk);             // R5 timeout
    chk("R5", "wait ended", int'(hs_wait), 0);
    chk("R5", "no release", int'(buf_release), 0);
    token_and_check("R5", 1, 1);                   // resend same PID
    send_ack(1);
    send_ack(0);                                    // R7 ack in idle ignored
    buf_ready = 1'b1;
    token_and_check("R7", 1, 0);                   // toggle stayed DATA0
    send_ack(1);
    // R9: ready pulses between tokens, low at the token
    buf_ready = 1'b0;
    @(negedge clk) buf_ready = 1'b1;
    @(negedge clk) buf_ready = 1'b0;
    token_and_check("R9", 2, 0);
    // R4: halt with ready -> STALL
    buf_ready = 1'b1; halt = 1'b1;
    token_and_check("R4", 3, 0);
    halt = 1'b0;                                    // R8 clear -> DATA0 (toggle was 1)
    @(negedge clk);
    token_and_check("R8", 1, 0);
    send_ack(1);
    // R1: reconfigure after toggle became 1
    @(negedge clk) ep_config = 1'b1;
    @(negedge clk) ep_config = 1'b0;
    token_and_check("R1", 1, 0);
    // R8 priority: ack together with halt falling edge
    halt = 1'b1;
    @(negedge clk);
    halt = 1'b0; hs_ack = 1'b1;
    @(negedge clk) hs_ack = 1'b0;
    chk("R8", "release with clear", int'(buf_release), 1);
    token_and_check("R8", 1, 0);
    repeat (LIMIT + 3) @(negedge clk);
    finish_run();
  end
endmodule